// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block runs one block-erase operation on a parallel NOR flash that uses the extended command set. A request carries a block address and a boot-protection enable. The block first checks the address against an erase geometry fixed by parameters. That geometry is a list of regions, each made of equal-size blocks. A bad request is refused at once and the flash bus is never touched.

An accepted request goes through these steps in order:
- The program-power enable is raised.
- The block issues the two-write erase command to the block address.
- It polls the status register until the ready bit shows or a millisecond-based timeout runs out.
- It lowers program power and issues a clear-status command.
- It issues a read-array command.
- It reports the result.

The bus is a simple synchronous strobe interface. Read data must be valid in the cycle after a read strobe. The result is a one-cycle `done` pulse plus an error vector and a timeout flag. Both stay stable until the next accepted request.

Top module: `flash_erase_seq`

## Requirements
- R1: A request is rejected when its address lies in no region or is not a multiple of the block size of its region, measured from the region base. With the default geometry, region 0 has 8 blocks of 0x1000 at base 0 and region 1 has 30 blocks of 0x8000 at base 0x8000. A rejection gives `done` two cycles after the `start` cycle, with err = 4'b0001 and timeout = 0, and no write, read or power strobe.
- R2: When `boot_prot` is high, any address inside the first block of region 0 is rejected in the same way as R1. When `boot_prot` is low, such an address is accepted.
- R3: For an accepted request, `prog_pwr` rises two cycles after the `start` cycle. It stays high through the last status read cycle and the wait cycle after it, and is low from the clear-status write onward.
- R4: The setup write (data 0x20) follows the power-on cycle. The confirm write (data 0xD0) comes in the next cycle. Both go to `blk_addr`.
- R5: Polling repeats a pair of cycles: one cycle with `bus_re` high, then one wait cycle. `bus_rdata` is sampled at the end of the wait cycle, and polling stops when bit 7 of it is 1.
- R6: Polling also stops, with `timeout` set, at the first sample taken at least TIMEOUT_MS*(CLK_HZ/1000) cycles after the first read-strobe cycle, counting that cycle as 0. A sample that shows ready wins over the timeout.
- R7: After polling, a write of 0x50 and then a write of 0xFF follow in consecutive cycles. In the next cycle `done` is high for exactly one cycle.
- R8: The error vector is {bit4|bit5, bit3, bit1, 0}, taken from the last sampled status. The fields are program/erase failure, low programming voltage, block locked, and rejected in bit 0. This decode applies on timeout too.
- R9: `start` is ignored while an operation is in progress. The address, the sequence and its outputs stay unchanged. `err` and `timeout` hold their values until the next accepted `start`, which clears them.
- R10: After reset all strobes, `prog_pwr`, `done`, `err` and `timeout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only when idle |
| blk_addr | input | ADDR_W | Block address of the request |
| boot_prot | input | 1 | Enables boot-block protection |
| bus_addr | output | ADDR_W | Flash address for strobes |
| bus_wdata | output | DATA_W | Flash command data |
| bus_we | output | 1 | Flash write strobe |
| bus_re | output | 1 | Flash read strobe |
| bus_rdata | input | DATA_W | Flash read data, valid the cycle after `bus_re` |
| prog_pwr | output | 1 | Program-power enable |
| done | output | 1 | One-cycle completion pulse |
| err | output | 4 | {prog/erase fail, low voltage, locked, rejected} |
| timeout | output | 1 | Polling ran out of time |

## Verification
A wrong sequencer state shows at the ports within a cycle, for several reasons:
- Every cycle of an operation has a fixed strobe, data and power pattern.
- A skipped or repeated state moves the pattern by at least one cycle.
- A wrong timer count moves the end of polling by one or more poll pairs, so `timeout` or the number of read strobes changes.
- A wrong validation decision moves `done` by many cycles and changes err bit 0.
- Stale or badly decoded status shows in `err` at the `done` cycle and in every idle cycle after it.

// File: rtl/fes_pkg.sv
package fes_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_PWR, S_SETUP, S_CONFIRM,
    S_POLL_RD, S_POLL_WT, S_CLEAR, S_RESET, S_DONE
  } fes_state_t;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;

  localparam int unsigned SB_READY = 7;
  localparam int unsigned SB_LOCK  = 1;
  localparam int unsigned SB_VOLT  = 3;
  localparam int unsigned SB_PROG  = 4;
  localparam int unsigned SB_ERASE = 5;

endpackage

// File: rtl/fes_region_check.sv
module fes_region_check #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned NREG   = 2,
  parameter logic [NREG*5-1:0]  BLK_LOG2 = {5'd15, 5'd12},
  parameter logic [NREG*16-1:0] BLK_CNT  = {16'd30, 16'd8}
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              boot_prot,
  output logic              ok
);
  localparam int unsigned AW1 = ADDR_W + 1;

  function automatic logic [AW1-1:0] region_base(int unsigned idx);
    logic [AW1-1:0] acc;
    acc = '0;
    for (int unsigned k = 0; k < idx; k++)
      acc = acc + (AW1'(BLK_CNT[k*16 +: 16]) << BLK_LOG2[k*5 +: 5]);
    return acc;
  endfunction

  localparam logic [AW1-1:0] BOOT_END = AW1'(1) << BLK_LOG2[4:0];

  logic [AW1-1:0]  a_ext;
  logic [NREG-1:0] hit;
  logic [NREG-1:0] aligned;

  assign a_ext = {1'b0, addr};

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    localparam logic [AW1-1:0] BASE  = region_base(gi);
    localparam logic [AW1-1:0] LIMIT = region_base(gi + 1);
    localparam logic [AW1-1:0] MASK  = (AW1'(1) << BLK_LOG2[gi*5 +: 5]) - AW1'(1);
    logic [AW1-1:0] rel;
    assign rel         = a_ext - BASE;
    assign hit[gi]     = (a_ext >= BASE) && (a_ext < LIMIT);
    assign aligned[gi] = (rel & MASK) == '0;
  end

  logic in_boot;
  assign in_boot = boot_prot && (a_ext < BOOT_END);
  assign ok      = (|(hit & aligned)) && !in_boot;

  always_comb begin
    assert ($countones(hit) <= 1)
      else $error("p_regions_disjoint_r1: address hits more than one region");
  end

endmodule

// File: rtl/fes_ms_timer.sv
module fes_ms_timer #(
  parameter int unsigned CYC_PER_MS = 125000,
  parameter int unsigned TIMEOUT_MS = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int unsigned PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam int unsigned MW = $clog2(TIMEOUT_MS + 1);
  localparam logic [PW-1:0] P_LAST = PW'(CYC_PER_MS - 1);
  localparam logic [MW-1:0] M_LIM  = MW'(TIMEOUT_MS);

  logic [PW-1:0] presc;
  logic [MW-1:0] ms;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      presc <= '0;
      ms    <= '0;
    end else if (presc == P_LAST) begin
      presc <= '0;
      if (ms != M_LIM) ms <= ms + MW'(1);
    end else begin
      presc <= presc + PW'(1);
    end
  end

  assign expired = (ms == M_LIM);

  p_ms_saturates_r6: assert property (@(posedge clk) disable iff (rst)
    ms <= M_LIM);
  p_ms_steps_by_one_r6: assert property (@(posedge clk) disable iff (rst)
    run && $past(run) && (ms != $past(ms)) |-> ms == $past(ms) + MW'(1));
  p_idle_clears_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> (ms == '0));

endmodule

// File: rtl/fes_status_decode.sv
module fes_status_decode #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] status,
  output logic [2:0]        flags
);
  import fes_pkg::*;

  always_comb begin
    flags[2] = status[SB_PROG] | status[SB_ERASE];
    flags[1] = status[SB_VOLT];
    flags[0] = status[SB_LOCK];
  end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned NREG       = 2,
  parameter logic [NREG*5-1:0]  BLK_LOG2 = {5'd15, 5'd12},
  parameter logic [NREG*16-1:0] BLK_CNT  = {16'd30, 16'd8},
  parameter int unsigned CLK_HZ     = 125000000,
  parameter int unsigned TIMEOUT_MS = 1500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] blk_addr,
  input  logic              boot_prot,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              prog_pwr,
  output logic              done,
  output logic [3:0]        err,
  output logic              timeout
);
  import fes_pkg::*;

  localparam int unsigned CYC_PER_MS = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;

  fes_state_t        state, nxt;
  logic [ADDR_W-1:0] addr_q;
  logic              boot_q;
  logic [DATA_W-1:0] stat_q;
  logic              tmo_q;
  logic              addr_ok;
  logic              expired;
  logic              polling;
  logic [2:0]        flags;

  fes_region_check #(
    .ADDR_W(ADDR_W), .NREG(NREG), .BLK_LOG2(BLK_LOG2), .BLK_CNT(BLK_CNT)
  ) i_check (
    .addr(addr_q), .boot_prot(boot_q), .ok(addr_ok)
  );

  assign polling = (state == S_POLL_RD) || (state == S_POLL_WT);

  fes_ms_timer #(
    .CYC_PER_MS(CYC_PER_MS), .TIMEOUT_MS(TIMEOUT_MS)
  ) i_timer (
    .clk(clk), .rst(rst), .run(polling), .expired(expired)
  );

  fes_status_decode #(.DATA_W(DATA_W)) i_decode (
    .status(stat_q), .flags(flags)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:    if (start) nxt = S_CHECK;
      S_CHECK:   nxt = addr_ok ? S_PWR : S_DONE;
      S_PWR:     nxt = S_SETUP;
      S_SETUP:   nxt = S_CONFIRM;
      S_CONFIRM: nxt = S_POLL_RD;
      S_POLL_RD: nxt = S_POLL_WT;
      S_POLL_WT: nxt = (bus_rdata[SB_READY] || expired) ? S_CLEAR : S_POLL_RD;
      S_CLEAR:   nxt = S_RESET;
      S_RESET:   nxt = S_DONE;
      S_DONE:    nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      addr_q    <= '0;
      boot_q    <= 1'b0;
      stat_q    <= '0;
      tmo_q     <= 1'b0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      bus_wdata <= '0;
      prog_pwr  <= 1'b0;
      done      <= 1'b0;
      err       <= '0;
      timeout   <= 1'b0;
    end else begin
      state    <= nxt;
      bus_we   <= (nxt == S_SETUP) || (nxt == S_CONFIRM) ||
                  (nxt == S_CLEAR) || (nxt == S_RESET);
      bus_re   <= (nxt == S_POLL_RD);
      prog_pwr <= (nxt == S_PWR) || (nxt == S_SETUP) || (nxt == S_CONFIRM) ||
                  (nxt == S_POLL_RD) || (nxt == S_POLL_WT);
      done     <= (nxt == S_DONE);
      unique case (nxt)
        S_SETUP:   bus_wdata <= DATA_W'(CMD_ERASE_SETUP);
        S_CONFIRM: bus_wdata <= DATA_W'(CMD_ERASE_GO);
        S_CLEAR:   bus_wdata <= DATA_W'(CMD_CLR_STATUS);
        S_RESET:   bus_wdata <= DATA_W'(CMD_READ_ARRAY);
        default:   bus_wdata <= '0;
      endcase
      if (state == S_IDLE && start) begin
        addr_q  <= blk_addr;
        boot_q  <= boot_prot;
        err     <= '0;
        timeout <= 1'b0;
      end
      if (state == S_CHECK && !addr_ok) err <= 4'b0001;
      if (state == S_POLL_WT) begin
        stat_q <= bus_rdata;
        tmo_q  <= !bus_rdata[SB_READY] && expired;
      end
      if (state == S_RESET) begin
        err     <= {flags, 1'b0};
        timeout <= tmo_q;
      end
    end
  end

  assign bus_addr = addr_q;

  p_setup_then_go_r4: assert property (@(posedge clk) disable iff (rst)
    bus_we && bus_wdata == DATA_W'(CMD_ERASE_SETUP)
    |=> bus_we && bus_wdata == DATA_W'(CMD_ERASE_GO));
  p_power_on_erase_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    bus_we && (bus_wdata == DATA_W'(CMD_ERASE_SETUP) ||
               bus_wdata == DATA_W'(CMD_ERASE_GO)) |-> prog_pwr);
  p_power_off_at_clear_r3: assert property (@(posedge clk) disable iff (rst)
    bus_we && bus_wdata == DATA_W'(CMD_CLR_STATUS) |-> !prog_pwr);
  p_clear_then_read_array_r7: assert property (@(posedge clk) disable iff (rst)
    bus_we && bus_wdata == DATA_W'(CMD_CLR_STATUS)
    |=> bus_we && bus_wdata == DATA_W'(CMD_READ_ARRAY));
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_reject_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    done && err[0] |-> !prog_pwr && !$past(bus_we) && !$past(bus_re));
  p_strobes_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re));
  p_addr_stable_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_we || bus_re) && $past(bus_we || bus_re || prog_pwr) |-> $stable(bus_addr));

endmodule

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;
  localparam int unsigned AW = 20;
  localparam int unsigned LIM = 3 * 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] blk_addr = '0;
  logic boot_prot = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic bus_we, bus_re;
  logic [7:0] bus_rdata = 8'h00;
  logic prog_pwr, done, timeout;
  logic [3:0] err;

  always #4 clk = ~clk;

  flash_erase_seq #(.ADDR_W(AW), .DATA_W(8), .CLK_HZ(8000), .TIMEOUT_MS(3)) i_flash_erase_seq (
    .clk(clk), .rst(rst), .start(start), .blk_addr(blk_addr), .boot_prot(boot_prot),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .prog_pwr(prog_pwr), .done(done), .err(err), .timeout(timeout));

  typedef struct {
    bit we; bit re; bit pwr; bit dn; logic [7:0] wd; logic [3:0] er; bit tm;
    logic [AW-1:0] ad; string tg;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0, cyc = 0;
  logic [3:0] last_err = 4'h0;
  bit last_tmo = 1'b0;
  string idle_tag = "R10";

  int rdy_at = 1000000, poll_n = 0;
  logic [7:0] rstat = 8'h80, bstat = 8'h00;

  always @(posedge clk) if (bus_re) begin
    poll_n = poll_n + 1;
    bus_rdata <= (poll_n >= rdy_at) ? rstat : bstat;
  end

  task automatic chk(string tg, string what, int act, int ex);
    checks++;
    if (act != ex) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tg, what, act, ex, cyc);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  always @(posedge clk) begin
    #2;
    if (!rst) begin
      exp_t e;
      if (q.size() > 0) e = q.pop_front();
      else begin
        e.we = 0; e.re = 0; e.pwr = 0; e.dn = 0; e.wd = 0;
        e.er = last_err; e.tm = last_tmo; e.ad = bus_addr; e.tg = idle_tag;
      end
      chk(e.tg, "we", bus_we, e.we);
      chk(e.tg, "re", bus_re, e.re);
      chk(e.tg, "pwr", prog_pwr, e.pwr);
      chk(e.tg, "done", done, e.dn);
      chk(e.tg, "err", err, e.er);
      chk(e.tg, "timeout", timeout, e.tm);
      if (e.we) chk(e.tg, "wdata", bus_wdata, e.wd);
      if (e.we || e.re) chk(e.tg, "addr", bus_addr, e.ad);
    end
  end

  function automatic void pe(bit we, bit re, bit pwr, bit dn, logic [7:0] wd,
                             logic [3:0] er, bit tm, logic [AW-1:0] ad, string tg);
    exp_t e;
    e.we = we; e.re = re; e.pwr = pwr; e.dn = dn; e.wd = wd;
    e.er = er; e.tm = tm; e.ad = ad; e.tg = tg;
    q.push_back(e);
  endfunction

  function automatic bit addr_ok(int a, bit bp);
    bit in0, in1, al;
    in0 = (a < 32'h8000);
    in1 = (a >= 32'h8000) && (a < 32'h8000 + 30 * 32'h8000);
    al  = in0 ? (a % 32'h1000 == 0) : ((a - 32'h8000) % 32'h8000 == 0);
    if (!(in0 || in1) || !al) return 0;
    if (bp && a < 32'h1000) return 0;
    return 1;
  endfunction

  task automatic run_erase(int a, bit bp, int r_at, logic [7:0] rs, logic [7:0] bs,
                           string tg, bit poke_busy);
    logic [7:0] st;
    bit tm;
    logic [3:0] er;
    @(negedge clk);
    rdy_at = r_at; rstat = rs; bstat = bs; poll_n = 0;
    pe(0, 0, 0, 0, 0, 4'h0, 0, AW'(a), tg);
    if (!addr_ok(a, bp)) begin
      pe(0, 0, 0, 1, 0, 4'h1, 0, AW'(a), tg);
      last_err = 4'h1; last_tmo = 0;
    end else begin
      pe(0, 0, 1, 0, 0, 4'h0, 0, AW'(a), tg);
      pe(1, 0, 1, 0, 8'h20, 4'h0, 0, AW'(a), tg);
      pe(1, 0, 1, 0, 8'hD0, 4'h0, 0, AW'(a), tg);
      for (int j = 1; ; j++) begin
        pe(0, 1, 1, 0, 0, 4'h0, 0, AW'(a), tg);
        pe(0, 0, 1, 0, 0, 4'h0, 0, AW'(a), tg);
        if (j >= r_at) begin st = rs; tm = 0; break; end
        if (2 * j - 1 >= LIM) begin st = bs; tm = 1; break; end
      end
      er = {st[4] | st[5], st[3], st[1], 1'b0};
      pe(1, 0, 0, 0, 8'h50, 4'h0, 0, AW'(a), tg);
      pe(1, 0, 0, 0, 8'hFF, 4'h0, 0, AW'(a), tg);
      pe(0, 0, 0, 1, 0, er, tm, AW'(a), tg);
      last_err = er; last_tmo = tm;
    end
    start = 1; blk_addr = AW'(a); boot_prot = bp;
    @(negedge clk);
    start = 0;
    if (poke_busy) begin
      repeat (5) @(negedge clk);
      start = 1; blk_addr = AW'(32'h1800); boot_prot = 1;
      @(negedge clk);
      start = 0;
    end
    while (q.size() > 0) @(negedge clk);
    idle_tag = (tg == "R9") ? "R9" : "R8";
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);                       // R10 reset state
    run_erase(32'h1000, 1, 3, 8'h80, 8'h00, "R4", 0);   // R3 R4 R5 R7
    run_erase(32'h1800, 0, 1, 8'h80, 8'h00, "R1", 0);   // misaligned region 0
    run_erase(32'h9000, 0, 1, 8'h80, 8'h00, "R1", 0);   // misaligned region 1
    run_erase(32'hF8000, 0, 1, 8'h80, 8'h00, "R1", 0);  // beyond last region
    run_erase(32'hF0000, 0, 1, 8'h80, 8'h00, "R1", 0);  // last block accepted
    run_erase(32'h0, 1, 1, 8'h80, 8'h00, "R2", 0);      // boot block protected
    run_erase(32'h0, 0, 2, 8'h80, 8'h00, "R2", 0);      // protection off
    run_erase(32'h8000, 0, 1000, 8'h80, 8'h12, "R6", 0);// timeout, busy status bits 1,4
    run_erase(32'h8000, 0, 13, 8'h80, 8'h00, "R6", 0);  // ready wins on last sample
    run_erase(32'h2000, 0, 12, 8'h80, 8'h00, "R6", 0);
    run_erase(32'h3000, 0, 2, 8'h8A, 8'h00, "R8", 0);   // voltage + lock
    run_erase(32'h4000, 0, 1, 8'hA0, 8'h00, "R8", 0);   // erase fail
    run_erase(32'h5000, 0, 3, 8'h90, 8'h00, "R8", 0);   // program fail
    run_erase(32'h10000, 0, 4, 8'h80, 8'h00, "R9", 1);  // start ignored while busy
    summary();
  end
endmodule